// File: doc/BRIEF.md
# Modulator Bitstream Output Interface

This block sits between the one-bit output of a delta-sigma modulator and the chip pins. It chooses where the modulator clock comes from, derives slower clocks from it, and decides how the bitstream reaches the data pin. A two-bit mode input picks one of four operating modes. Three of these modes drive a clock on the pin from an internal source. In the fourth, the pin is an input that supplies the clock. The data pin carries either the raw bitstream or a split-phase (Manchester) coded version of it.

All logic runs on one fast system clock. The internal clock source arrives as a strobe, `intTick`, with one pulse for every half-period of the modulator clock. In external mode, every edge of the clock pin counts as one half-period, after the pin has passed through a two-flop synchronizer. A three-bit half-period counter produces the modulator clock and its divide-by-2 and divide-by-4 versions. The bidirectional clock pin is modelled as three separate signals: an input, an output and an output enable. Each time the mode input changes, the counter and the captured data bit restart from zero. This keeps short pulses off the clock pin.

Top module: `mbi_top`

## Requirements
- R1: The clock-pin output enable `pinClkOe` is 0 exactly when the mode registered on the previous clock edge is 3 (`modeSel`=2'b11). It is 1 for modes 0, 1 and 2.
- R2: Every accepted half-period tick increments a three-bit count n, which wraps modulo 8. `clkDiv2` equals bit 1 of n and `clkDiv4` equals bit 2 of n. The modulator clock is bit 0 of n.
- R3: In mode 0 (2'b00), `pinClkOut` equals bit 0 of n. `pinData` takes the value of `modBit` on each tick that makes n odd, which is each rising edge of `pinClkOut`. It does not change at any other time.
- R4: In mode 1 (2'b01), `pinClkOut` equals bit 1 of n, which is the half-rate clock. `pinData` takes `modBit` on each tick that makes n mod 4 equal to 2, and it stays constant while `pinClkOut` is high.
- R5: In mode 2 (2'b10), `pinClkOut` equals bit 0 of n. A bit b is captured on each tick that makes n mod 4 equal to 2. `pinData` is b while bit 1 of n is 1 and the inverse of b while bit 1 of n is 0. A captured 1 therefore goes out high then low, and a 0 goes out low then high, with each half lasting one modulator clock.
- R6: In mode 3 (2'b11), each edge of `pinClkIn` counts as one half-period tick and takes effect three system clocks later. Capture and output behave as in mode 0. `intTick` pulses have no effect in this mode.
- R7: A change on `modeSel` clears n and the captured bit on the next clock edge. That tick is ignored. Right after the change, `pinClkOut`, `clkDiv2` and `clkDiv4` are 0, and `pinData` is 1 in mode 2 and 0 otherwise.
- R8: While `rst` is high, and right after it falls with `modeSel`=0, the outputs are: `pinClkOut`=0, `pinData`=0, `clkDiv2`=0, `clkDiv4`=0 and `pinClkOe`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than any modulator clock edge |
| rst | input | 1 | Synchronous active-high reset |
| modeSel | input | 2 | Operating mode select |
| intTick | input | 1 | Internal clock source, one pulse per half modulator period |
| modBit | input | 1 | Modulator one-bit data stream |
| pinClkIn | input | 1 | Clock pin, input side |
| pinClkOut | output | 1 | Clock pin, output side |
| pinClkOe | output | 1 | Clock pin output enable |
| pinData | output | 1 | Data pin |
| clkDiv2 | output | 1 | Modulator clock divided by two |
| clkDiv4 | output | 1 | Modulator clock divided by four |

## Verification
The hardest case to reach from the ports is a mode switch in the middle of a stream. The counter must then be partway through a period, with a non-zero captured bit, so that the forced restart is visible on the outputs. The stimulus builds this up deliberately. It runs several ticks in one mode so that the clock output is high and a 1 has been captured, then changes the mode and checks the restart values. External mode is reached only through pin edges, which pass through the synchronizer delay. The bench therefore mixes pin toggles with stray `intTick` pulses and checks that only the toggles move the count.

// File: rtl/mbi_pkg.sv
package mbi_pkg;
  localparam int CNT_W = 3;
  localparam int SYNC_STAGES = 2;

  typedef enum logic [1:0] {
    MODE_DIRECT = 2'b00,
    MODE_HALF   = 2'b01,
    MODE_SPLIT  = 2'b10,
    MODE_EXTCLK = 2'b11
  } ifMode_e;

  typedef struct packed {
    logic restart;
    logic halfTick;
    logic useHalfClk;
    logic splitPhase;
    logic drvClk;
  } ctrlStrobe_t;
endpackage

// File: rtl/mbi_ctrl.sv
module mbi_ctrl
  import mbi_pkg::*;
#(
  parameter int SYNC_N = SYNC_STAGES
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [1:0]  modeSel,
  input  logic        intTick,
  input  logic        pinClkIn,
  output ctrlStrobe_t ctrl
);
  localparam int CHAIN_W = SYNC_N + 1;

  logic [1:0]         modeQ;
  logic [CHAIN_W-1:0] syncChain;
  logic               extEdge;

  always_ff @(posedge clk) begin
    if (rst) begin
      modeQ     <= MODE_DIRECT;
      syncChain <= '0;
    end else begin
      modeQ     <= modeSel;
      syncChain <= {syncChain[CHAIN_W-2:0], pinClkIn};
    end
  end

  // Top stage holds the previous synchronized level; any difference is an edge.
  assign extEdge = syncChain[CHAIN_W-1] ^ syncChain[CHAIN_W-2];

  always_comb begin
    ctrl.restart    = (modeSel != modeQ);
    ctrl.useHalfClk = (modeQ == MODE_HALF);
    ctrl.splitPhase = (modeQ == MODE_SPLIT);
    ctrl.drvClk     = (modeQ != MODE_EXTCLK);
    ctrl.halfTick   = (modeQ == MODE_EXTCLK) ? extEdge : intTick;
  end
endmodule

// File: rtl/mbi_datapath.sv
module mbi_datapath
  import mbi_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic        clk,
  input  logic        rst,
  input  ctrlStrobe_t ctrl,
  input  logic        modBit,
  output logic        pinClkOut,
  output logic        pinClkOe,
  output logic        pinData,
  output logic        clkDiv2,
  output logic        clkDiv4
);
  logic [CW-1:0] halfCnt;
  logic [CW-1:0] cntNext;
  logic          bitQ;
  logic          captureNow;

  assign cntNext = halfCnt + 1'b1;

  always_comb begin
    if (ctrl.useHalfClk || ctrl.splitPhase)
      captureNow = ctrl.halfTick && (cntNext[1:0] == 2'b10);
    else
      captureNow = ctrl.halfTick && cntNext[0];
  end

  always_ff @(posedge clk) begin
    if (rst || ctrl.restart) begin
      halfCnt <= '0;
      bitQ    <= 1'b0;
    end else if (ctrl.halfTick) begin
      halfCnt <= cntNext;
      if (captureNow) bitQ <= modBit;
    end
  end

  assign clkDiv2   = halfCnt[1];
  assign clkDiv4   = halfCnt[2];
  assign pinClkOut = ctrl.useHalfClk ? halfCnt[1] : halfCnt[0];
  assign pinClkOe  = ctrl.drvClk;
  assign pinData   = ctrl.splitPhase ? (bitQ ^ ~halfCnt[1]) : bitQ;
endmodule

// File: rtl/mbi_top.sv
module mbi_top
  import mbi_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] modeSel,
  input  logic       intTick,
  input  logic       modBit,
  input  logic       pinClkIn,
  output logic       pinClkOut,
  output logic       pinClkOe,
  output logic       pinData,
  output logic       clkDiv2,
  output logic       clkDiv4
);
  ctrlStrobe_t ctrl;

  mbi_ctrl #(.SYNC_N(SYNC_STAGES)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .modeSel  (modeSel),
    .intTick  (intTick),
    .pinClkIn (pinClkIn),
    .ctrl     (ctrl)
  );

  mbi_datapath #(.CW(CNT_W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .ctrl      (ctrl),
    .modBit    (modBit),
    .pinClkOut (pinClkOut),
    .pinClkOe  (pinClkOe),
    .pinData   (pinData),
    .clkDiv2   (clkDiv2),
    .clkDiv4   (clkDiv4)
  );
endmodule

// File: rtl/mbi_checker.sv
module mbi_checker (
  input logic       clk,
  input logic       rst,
  input logic [1:0] modeSel,
  input logic       pinClkOut,
  input logic       pinClkOe,
  input logic       pinData,
  input logic       clkDiv2,
  input logic       clkDiv4
);
  logic [1:0] armCnt;
  logic       armed;

  always_ff @(posedge clk) begin
    if (rst) armCnt <= '0;
    else if (armCnt != 2'd3) armCnt <= armCnt + 1'b1;
  end
  assign armed = (armCnt == 2'd3);

  a_r1_oe_follows_mode: assert property (@(posedge clk) disable iff (rst)
    armed |-> (pinClkOe == ($past(modeSel) != 2'b11)));

  a_r7_restart_clears: assert property (@(posedge clk) disable iff (rst)
    (armed && modeSel != $past(modeSel)) |=> (!clkDiv2 && !clkDiv4 && !pinClkOut));

  a_r3_data_on_rise: assert property (@(posedge clk) disable iff (rst)
    (armed && modeSel == 2'b00 && $past(modeSel) == 2'b00 && $past(modeSel, 2) == 2'b00
     && pinData != $past(pinData)) |-> $rose(pinClkOut));

  a_r4_hold_high_phase: assert property (@(posedge clk) disable iff (rst)
    (armed && modeSel == 2'b01 && $past(modeSel) == 2'b01
     && pinClkOut && $past(pinClkOut)) |-> $stable(pinData));

  a_r5_mid_bit_flip: assert property (@(posedge clk) disable iff (rst)
    (armed && modeSel == 2'b10 && $past(modeSel) == 2'b10 && $past(modeSel, 2) == 2'b10
     && $fell(clkDiv2)) |-> (pinData != $past(pinData)));
endmodule

bind mbi_top mbi_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .modeSel   (modeSel),
  .pinClkOut (pinClkOut),
  .pinClkOe  (pinClkOe),
  .pinData   (pinData),
  .clkDiv2   (clkDiv2),
  .clkDiv4   (clkDiv4)
);

// File: tb/mbi_top_tb.sv
`timescale 1ns/1ps
module mbi_top_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] modeSel = 2'b00;
  logic intTick = 1'b0;
  logic modBit = 1'b0;
  logic pinClkIn = 1'b0;
  logic pinClkOut, pinClkOe, pinData, clkDiv2, clkDiv4;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int n = 0;
  logic expBit = 1'b0;
  logic [7:0] pat = '0;

  always #2.5 clk = ~clk;

  mbi_top u_dut (
    .clk(clk), .rst(rst), .modeSel(modeSel), .intTick(intTick),
    .modBit(modBit), .pinClkIn(pinClkIn), .pinClkOut(pinClkOut),
    .pinClkOe(pinClkOe), .pinData(pinData), .clkDiv2(clkDiv2), .clkDiv4(clkDiv4)
  );

  typedef struct packed {
    logic [1:0] mode;
    logic [7:0] bits;
    logic [4:0] ticks;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{2'b00, 8'b10110010, 5'd16},
    '{2'b00, 8'b01011100, 5'd16},
    '{2'b01, 8'b11010110, 5'd16},
    '{2'b01, 8'b00101101, 5'd16},
    '{2'b10, 8'b11001010, 5'd16},
    '{2'b10, 8'b01110001, 5'd16}
  };

  task automatic check(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s at n=%0d mode=%0d: actual %b expected %b", tag, n, modeSel, got, exp);
    end
  endtask

  task automatic waitCycles(input int k);
    repeat (k) @(negedge clk);
  endtask

  // Restart into mode m by passing through another mode first.
  task automatic enterMode(input logic [1:0] m);
    modeSel = m ^ 2'b01;
    waitCycles(2);
    modeSel = m;
    waitCycles(2);
    n = 0;
    expBit = 1'b0;
  endtask

  function automatic logic expClk(input logic [1:0] m, input int cnt);
    return (m == 2'b01) ? cnt[1] : cnt[0];
  endfunction

  function automatic logic expData(input logic [1:0] m, input int cnt, input logic b);
    return (m == 2'b10) ? (b ^ ~cnt[1]) : b;
  endfunction

  task automatic noteCapture(input logic [1:0] m);
    if (m == 2'b01 || m == 2'b10) begin
      if ((n % 4) == 2) expBit = pat[n % 8];
    end else if (n[0]) begin
      expBit = pat[n % 8];
    end
  endtask

  task automatic checkAll(input logic [1:0] m);
    string t;
    t = (m == 2'b00) ? "R3" : (m == 2'b01) ? "R4" : (m == 2'b10) ? "R5" : "R6";
    check({t, " clk"}, pinClkOut, expClk(m, n));
    check({t, " data"}, pinData, expData(m, n, expBit));
    check("R2 div2", clkDiv2, n[1]);
    check("R2 div4", clkDiv4, n[2]);
    check("R1 oe", pinClkOe, m != 2'b11);
  endtask

  task automatic intPulse();
    modBit = pat[(n + 1) % 8];
    intTick = 1'b1;
    @(negedge clk);
    intTick = 1'b0;
    @(negedge clk);
  endtask

  task automatic extToggle();
    modBit = pat[(n + 1) % 8];
    pinClkIn = ~pinClkIn;
    waitCycles(5);
  endtask

  initial begin
    waitCycles(3);
    // R8 reset state
    check("R8 clk", pinClkOut, 1'b0);
    check("R8 data", pinData, 1'b0);
    check("R8 div2", clkDiv2, 1'b0);
    check("R8 div4", clkDiv4, 1'b0);
    check("R8 oe", pinClkOe, 1'b1);
    rst = 1'b0;
    waitCycles(2);
    check("R8 clk after release", pinClkOut, 1'b0);
    check("R8 oe after release", pinClkOe, 1'b1);

    // Table walk over internal-clock modes
    foreach (VECS[i]) begin
      pat = VECS[i].bits;
      enterMode(VECS[i].mode);
      checkAll(VECS[i].mode);
      for (int k = 0; k < int'(VECS[i].ticks); k++) begin
        intPulse();
        n++;
        noteCapture(VECS[i].mode);
        checkAll(VECS[i].mode);
      end
    end

    // R6 external clock through the pin; intTick ignored
    pat = 8'b10011011;
    enterMode(2'b11);
    checkAll(2'b11);
    for (int k = 0; k < 12; k++) begin
      extToggle();
      n++;
      noteCapture(2'b11);
      checkAll(2'b11);
      intPulse();
      check("R6 intTick ignored clk", pinClkOut, expClk(2'b11, n));
      check("R6 intTick ignored div2", clkDiv2, n[1]);
      check("R6 intTick ignored data", pinData, expData(2'b11, n, expBit));
    end

    // R7 mid-stream restart: mode 0 with clock high and a 1 captured, then mode 2
    pat = 8'b11111111;
    enterMode(2'b00);
    for (int k = 0; k < 3; k++) begin
      intPulse();
      n++;
      noteCapture(2'b00);
    end
    check("R7 precondition clk", pinClkOut, 1'b1);
    check("R7 precondition data", pinData, 1'b1);
    modeSel = 2'b10;
    waitCycles(1);
    check("R7 restart clk", pinClkOut, 1'b0);
    check("R7 restart div2", clkDiv2, 1'b0);
    waitCycles(1);
    check("R7 restart split data", pinData, 1'b1);
    check("R7 restart oe", pinClkOe, 1'b1);
    n = 0;
    expBit = 1'b0;
    for (int k = 0; k < 6; k++) begin
      intPulse();
      n++;
      noteCapture(2'b10);
    end
    check("R7 split running div2", clkDiv2, 1'b1);
    modeSel = 2'b01;
    waitCycles(2);
    check("R7 restart to half clk", pinClkOut, 1'b0);
    check("R7 restart to half data", pinData, 1'b0);
    check("R7 restart to half div4", clkDiv4, 1'b0);
    modeSel = 2'b11;
    waitCycles(2);
    check("R1 oe off in mode 3", pinClkOe, 1'b0);

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule